// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the instruction decoder at the pins of a serial flash slave. It oversamples chip select, serial clock and serial data in on a system clock and accepts single-lane SPI frames in clock polarity mode 0 and mode 3. From each frame it picks out an 8-bit opcode, up to three address bytes and one data byte. It answers the three identification reads from fixed identifier parameters on a serial output with a separate drive enable.

The block owns a write-enable latch and a one-shot flag that selects the volatile status copy. Commands that modify the device are passed on as single-cycle strobes only when the latch is set. These are status writes, program, sector/block/chip erase and security-register erase/program. The strobe carries the opcode and address for an external array controller, or the data byte for an external status register. Each accepted strobe clears the latch again. Security-register commands are also checked against the legal register address windows before they pass.

Top module: `spi_flash_cmd_fe`

## Requirements
- R1: Opcode, address and data bits are taken MSB first on rising serial clock edges, and a frame behaves the same whether the clock idles low (mode 0) or high (mode 3) while chip select is high.
- R2: A frame of exactly one byte 0x06, ended by chip select rising, sets `wel` to 1.
- R3: When `wel` is 0, program (0x02), sector erase (0x20), block erase (0xD8), chip erase (0xC7 or 0x60), security erase/program (0x44/0x42) and a status write (0x01) not preceded by 0x50 produce no strobe and leave `wel` at 0.
- R4: An accepted modifying command gives exactly one single-cycle pulse on `modifyStb` (with `modifyCode` and the 24-bit `modifyAddr`, which is 0 for chip erase) or on `statusWrStb`, and `wel` reads 0 from that cycle on. Address commands need at least four whole bytes, chip erase exactly one, and a status write at least two. Every frame must end on a byte boundary.
- R5: A one-byte 0x50 frame arms the volatile flag (`volSel`=1). A following 0x01 frame is accepted even with `wel`=0, and its strobe has `statusWrVolatile`=1. Any other completed frame clears the flag, so a status write after it follows R3.
- R6: `sdoEn` is 0 while chip select is high, while the opcode is shifted in, and throughout any command that returns no data.
- R7: For 0x90, after three address bytes the output streams manufacturer, device, manufacturer, … until chip select rises. Address bit 0 = 1 starts with the device byte instead.
- R8: For 0x9F, right after the opcode the output streams manufacturer, memory type and capacity, repeating in that order.
- R9: For 0xAB, after three dummy bytes the device byte is sent repeatedly.
- R10: 0x44/0x42 are accepted only if address bits 23..16 are 0x00 and bits 15..8 are 0x10, 0x20 or 0x30.
- R11: A frame ended before eight clock bits changes neither `wel` nor `volSel` and gives no strobe.
- R12: Output bits change after a falling serial clock edge, MSB first, so the host can read each bit at the next rising edge.
- R13: After reset, `wel`, `volSel`, `sdoEn`, `statusWrStb` and `modifyStb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, valid when `sdoEn` is 1 |
| sdoEn | output | 1 | Output drive enable; 0 means high impedance at the pad |
| wel | output | 1 | Write-enable latch |
| volSel | output | 1 | Volatile status write armed |
| statusWrStb | output | 1 | One-cycle pulse for an accepted status write |
| statusWrVolatile | output | 1 | Status write targets the volatile copy |
| statusWrData | output | 8 | Status byte for the write |
| modifyStb | output | 1 | One-cycle pulse for an accepted program/erase command |
| modifyCode | output | 8 | Opcode of the accepted command |
| modifyAddr | output | 24 | Address of the accepted command |

## Verification
The bench builds the block with three synchronizer stages and identifier values that differ from the defaults in every byte. This shows that each streamed byte comes from its own parameter and that the longer input path still meets the serial timing. The serial clock runs at one sixteenth of the system clock, so output is sampled late in each low phase, just before the rising edge. Distinct identifier bytes let the wrap order of all three ID reads be told apart, including the swapped 0x90 order. The 0x50 arm-then-clear rule and the address windows of the security commands are covered by both accepted and refused frames.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam logic [7:0] OP_WREN     = 8'h06;
  localparam logic [7:0] OP_VOLARM   = 8'h50;
  localparam logic [7:0] OP_WRSTAT   = 8'h01;
  localparam logic [7:0] OP_PROG     = 8'h02;
  localparam logic [7:0] OP_SECTER   = 8'h20;
  localparam logic [7:0] OP_BLKER    = 8'hD8;
  localparam logic [7:0] OP_CHIPER_A = 8'hC7;
  localparam logic [7:0] OP_CHIPER_B = 8'h60;
  localparam logic [7:0] OP_SRERASE  = 8'h44;
  localparam logic [7:0] OP_SRPROG   = 8'h42;
  localparam logic [7:0] OP_IDPAIR   = 8'h90;
  localparam logic [7:0] OP_IDJEDEC  = 8'h9F;
  localparam logic [7:0] OP_IDWAKE   = 8'hAB;

  localparam int ADDR_BYTES = 3;
  localparam int ADDR_W     = 8 * ADDR_BYTES;

  // frame state seen by the control
  typedef struct packed {
    logic [7:0]        opcode;
    logic [ADDR_W-1:0] addr;
    logic [2:0]        byteCnt;   // whole bytes received, saturates at 7
    logic [2:0]        bitIdx;    // bits of the current byte received
    logic [1:0]        streamIdx; // index of the byte being sent
    logic              csRise;    // frame end event
  } dpStat_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       txActive;
    logic [7:0] txByte;
    logic [1:0] streamLast;
  } ctrlStrb_t;

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int                 STAGES  = 2,
  parameter int                 WIDTH   = 1,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= RST_VAL;
        else       stage <= din;
      end
      assign dout = stage;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= {STAGES{RST_VAL}};
        else       stage <= {stage[STAGES-2:0], din};
      end
      assign dout = stage[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spi_cmd_dp.sv
module spi_cmd_dp
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      sclk,
  input  logic      sdi,
  input  ctrlStrb_t ctrl,
  output dpStat_t   stat,
  output logic      sdo,
  output logic      sdoEn
);

  localparam int PIN_W = 3;

  logic [PIN_W-1:0] pinsS;
  logic csS, sclkS, sdiS;
  logic csD, sclkD;
  logic sclkRise, sclkFall;

  spi_cmd_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (PIN_W),
    .RST_VAL(3'b100)
  ) i_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({csN, sclk, sdi}),
    .dout(pinsS)
  );

  assign {csS, sclkS, sdiS} = pinsS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csD   <= 1'b1;
      sclkD <= 1'b0;
    end else begin
      csD   <= csS;
      sclkD <= sclkS;
    end
  end

  assign sclkRise = !csS && sclkS && !sclkD;
  assign sclkFall = !csS && !sclkS && sclkD;

  logic [6:0]        shiftReg;
  logic [7:0]        opcode;
  logic [7:0]        addrByte [ADDR_BYTES];
  logic [2:0]        byteCnt;
  logic [2:0]        bitIdx;
  logic [1:0]        streamIdx;
  logic              sdoBit;
  logic              sdoDrv;
  logic [7:0]        byteNow;

  assign byteNow = {shiftReg, sdiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      opcode    <= '0;
      for (int i = 0; i < ADDR_BYTES; i++) addrByte[i] <= '0;
      byteCnt   <= '0;
      bitIdx    <= '0;
      streamIdx <= '0;
      sdoBit    <= 1'b0;
      sdoDrv    <= 1'b0;
    end else if (csS) begin
      byteCnt   <= '0;
      bitIdx    <= '0;
      streamIdx <= '0;
      sdoDrv    <= 1'b0;
    end else begin
      if (sclkRise) begin
        shiftReg <= byteNow[6:0];
        bitIdx   <= bitIdx + 3'd1;
        if (bitIdx == 3'd7) begin
          if (byteCnt == 3'd0) opcode <= byteNow;
          for (int i = 0; i < ADDR_BYTES; i++) begin
            if (byteCnt == 3'(i + 1)) addrByte[i] <= byteNow;
          end
          if (byteCnt != 3'd7) byteCnt <= byteCnt + 3'd1;
          if (ctrl.txActive) begin
            streamIdx <= (streamIdx == ctrl.streamLast) ? 2'd0 : streamIdx + 2'd1;
          end
        end
      end
      if (sclkFall) begin
        sdoDrv <= ctrl.txActive;
        if (ctrl.txActive) sdoBit <= ctrl.txByte[~bitIdx];
      end
    end
  end

  assign stat.opcode    = opcode;
  assign stat.addr      = {addrByte[0], addrByte[1], addrByte[2]};
  assign stat.byteCnt   = byteCnt;
  assign stat.bitIdx    = bitIdx;
  assign stat.streamIdx = streamIdx;
  assign stat.csRise    = csS && !csD;

  assign sdo   = sdoBit;
  assign sdoEn = sdoDrv;

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter logic [7:0] MFR_ID   = 8'hA5,
  parameter logic [7:0] DEV_ID   = 8'h17,
  parameter logic [7:0] MEM_TYPE = 8'h40,
  parameter logic [7:0] CAPACITY = 8'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStat_t           stat,
  output ctrlStrb_t         ctrl,
  output logic              wel,
  output logic              volSel,
  output logic              statusWrStb,
  output logic              statusWrVolatile,
  output logic [7:0]        statusWrData,
  output logic              modifyStb,
  output logic [7:0]        modifyCode,
  output logic [ADDR_W-1:0] modifyAddr
);

  localparam logic [2:0] ADDR_DONE = 3'(1 + ADDR_BYTES);

  logic opValid, aligned, secOk;
  logic isAddrCmd, isChipCmd, isSecCmd;
  logic acceptWren, acceptVolArm, acceptStatus, acceptModify;

  assign opValid = stat.byteCnt != 3'd0;
  assign aligned = stat.bitIdx == 3'd0;

  assign secOk = (stat.addr[23:16] == 8'h00) &&
                 ((stat.addr[15:8] == 8'h10) || (stat.addr[15:8] == 8'h20) ||
                  (stat.addr[15:8] == 8'h30));

  assign isAddrCmd = (stat.opcode == OP_PROG) || (stat.opcode == OP_SECTER) ||
                     (stat.opcode == OP_BLKER);
  assign isChipCmd = (stat.opcode == OP_CHIPER_A) || (stat.opcode == OP_CHIPER_B);
  assign isSecCmd  = (stat.opcode == OP_SRERASE) || (stat.opcode == OP_SRPROG);

  assign acceptWren   = aligned && stat.byteCnt == 3'd1 && stat.opcode == OP_WREN;
  assign acceptVolArm = aligned && stat.byteCnt == 3'd1 && stat.opcode == OP_VOLARM;
  assign acceptStatus = aligned && stat.byteCnt >= 3'd2 && stat.opcode == OP_WRSTAT &&
                        (wel || volSel);
  assign acceptModify = aligned && wel &&
                        ((isAddrCmd && stat.byteCnt >= ADDR_DONE) ||
                         (isChipCmd && stat.byteCnt == 3'd1) ||
                         (isSecCmd && stat.byteCnt >= ADDR_DONE && secOk));

  // identification stream selection
  always_comb begin
    ctrl.txActive   = 1'b0;
    ctrl.txByte     = 8'h00;
    ctrl.streamLast = 2'd0;
    if (opValid) begin
      unique case (stat.opcode)
        OP_IDJEDEC: begin
          ctrl.txActive   = 1'b1;
          ctrl.streamLast = 2'd2;
          case (stat.streamIdx)
            2'd0:    ctrl.txByte = MFR_ID;
            2'd1:    ctrl.txByte = MEM_TYPE;
            default: ctrl.txByte = CAPACITY;
          endcase
        end
        OP_IDPAIR: begin
          ctrl.txActive   = stat.byteCnt >= ADDR_DONE;
          ctrl.streamLast = 2'd1;
          ctrl.txByte     = (stat.streamIdx[0] ^ stat.addr[0]) ? DEV_ID : MFR_ID;
        end
        OP_IDWAKE: begin
          ctrl.txActive   = stat.byteCnt >= ADDR_DONE;
          ctrl.streamLast = 2'd0;
          ctrl.txByte     = DEV_ID;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel              <= 1'b0;
      volSel           <= 1'b0;
      statusWrStb      <= 1'b0;
      statusWrVolatile <= 1'b0;
      statusWrData     <= '0;
      modifyStb        <= 1'b0;
      modifyCode       <= '0;
      modifyAddr       <= '0;
    end else begin
      statusWrStb <= 1'b0;
      modifyStb   <= 1'b0;
      if (stat.csRise && opValid) begin
        if (acceptWren) begin
          wel    <= 1'b1;
          volSel <= 1'b0;
        end else if (acceptVolArm) begin
          volSel <= 1'b1;
        end else begin
          volSel <= 1'b0;
          if (acceptStatus) begin
            statusWrStb      <= 1'b1;
            statusWrVolatile <= volSel;
            statusWrData     <= stat.addr[23:16];
            wel              <= 1'b0;
          end else if (acceptModify) begin
            modifyStb  <= 1'b1;
            modifyCode <= stat.opcode;
            modifyAddr <= isChipCmd ? '0 : stat.addr;
            wel        <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_flash_cmd_fe.sv
module spi_flash_cmd_fe
  import spi_cmd_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] MFR_ID      = 8'hA5,
  parameter logic [7:0] DEV_ID      = 8'h17,
  parameter logic [7:0] MEM_TYPE    = 8'h40,
  parameter logic [7:0] CAPACITY    = 8'h18
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        sdi,
  output logic        sdo,
  output logic        sdoEn,
  output logic        wel,
  output logic        volSel,
  output logic        statusWrStb,
  output logic        statusWrVolatile,
  output logic [7:0]  statusWrData,
  output logic        modifyStb,
  output logic [7:0]  modifyCode,
  output logic [23:0] modifyAddr
);

  dpStat_t   stat;
  ctrlStrb_t ctrl;

  spi_cmd_dp #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_dp (
    .clk  (clk),
    .rstN (rstN),
    .csN  (csN),
    .sclk (sclk),
    .sdi  (sdi),
    .ctrl (ctrl),
    .stat (stat),
    .sdo  (sdo),
    .sdoEn(sdoEn)
  );

  spi_cmd_ctrl #(
    .MFR_ID  (MFR_ID),
    .DEV_ID  (DEV_ID),
    .MEM_TYPE(MEM_TYPE),
    .CAPACITY(CAPACITY)
  ) i_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .stat            (stat),
    .ctrl            (ctrl),
    .wel             (wel),
    .volSel          (volSel),
    .statusWrStb     (statusWrStb),
    .statusWrVolatile(statusWrVolatile),
    .statusWrData    (statusWrData),
    .modifyStb       (modifyStb),
    .modifyCode      (modifyCode),
    .modifyAddr      (modifyAddr)
  );

endmodule

// File: rtl/spi_flash_cmd_fe_chk.sv
module spi_flash_cmd_fe_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic        csN,
  input logic        sdoEn,
  input logic        wel,
  input logic        statusWrStb,
  input logic        modifyStb,
  input logic [7:0]  modifyCode,
  input logic [23:0] modifyAddr
);

  logic [7:0] csHighCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        csHighCnt <= '0;
    else if (!csN)    csHighCnt <= '0;
    else if (csHighCnt != 8'hFF) csHighCnt <= csHighCnt + 8'd1;
  end

  // R6
  cs_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (32'(csHighCnt) > SYNC_STAGES + 2) |-> !sdoEn);

  // R4
  strobe_clears_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWrStb || modifyStb) |-> !wel);

  // R3
  modify_needs_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    modifyStb |-> $past(wel));

  // R4
  modify_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    modifyStb |=> !modifyStb);

  // R4
  status_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWrStb |=> !statusWrStb);

  // R4
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(statusWrStb && modifyStb));

  // R2
  wel_sets_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> csN);

  // R10
  security_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modifyStb && (modifyCode == 8'h44 || modifyCode == 8'h42)) |->
      (modifyAddr[23:16] == 8'h00 &&
       (modifyAddr[15:8] == 8'h10 || modifyAddr[15:8] == 8'h20 || modifyAddr[15:8] == 8'h30)));

endmodule

bind spi_flash_cmd_fe spi_flash_cmd_fe_chk #(.SYNC_STAGES(SYNC_STAGES)) i_chk (.*);

// File: tb/test_spi_flash_cmd_fe.sv
module test_spi_flash_cmd_fe;

  localparam int         HALF  = 8;
  localparam logic [7:0] T_MFR = 8'hC2;
  localparam logic [7:0] T_DEV = 8'h3B;
  localparam logic [7:0] T_TYP = 8'h61;
  localparam logic [7:0] T_CAP = 8'h19;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdoEn, wel, volSel;
  logic statusWrStb, statusWrVolatile, modifyStb;
  logic [7:0] statusWrData, modifyCode;
  logic [23:0] modifyAddr;

  always #4 clk = ~clk;

  spi_flash_cmd_fe #(
    .SYNC_STAGES(3),
    .MFR_ID     (T_MFR),
    .DEV_ID     (T_DEV),
    .MEM_TYPE   (T_TYP),
    .CAPACITY   (T_CAP)
  ) i_spi_flash_cmd_fe (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdoEn(sdoEn), .wel(wel), .volSel(volSel),
    .statusWrStb(statusWrStb), .statusWrVolatile(statusWrVolatile),
    .statusWrData(statusWrData), .modifyStb(modifyStb),
    .modifyCode(modifyCode), .modifyAddr(modifyAddr)
  );

  int nChk = 0;
  int nFail = 0;
  int nStat = 0;
  int nMod = 0;
  bit mode3 = 1'b0;
  bit enSeen = 1'b0;
  bit done = 1'b0;
  logic [7:0]  lastStatData;
  logic        lastStatVol;
  logic [7:0]  lastModCode;
  logic [23:0] lastModAddr;

  always @(posedge clk) begin
    if (rstN && statusWrStb) begin
      nStat <= nStat + 1;
      lastStatData <= statusWrData;
      lastStatVol  <= statusWrVolatile;
    end
    if (rstN && modifyStb) begin
      nMod <= nMod + 1;
      lastModCode <= modifyCode;
      lastModAddr <= modifyAddr;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spiBegin(input bit m3);
    mode3 = m3;
    sclk = m3;
    repeat (4) @(negedge clk);
    csN = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic spiBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      sdi = tx[7-i];
      repeat (HALF) @(negedge clk);
      rx[7-i] = sdo;
      if (sdoEn) enSeen = 1'b1;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx);
    spiBits(tx, 8, rx);
  endtask

  task automatic spiEnd();
    if (!mode3) sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (14) @(negedge clk);
  endtask

  // whole frame: opcode, optional address bytes, optional data byte
  task automatic frame(input logic [7:0] op, input int nAddr, input logic [23:0] a,
                       input bit hasData, input logic [7:0] d);
    logic [7:0] rx;
    spiBegin(1'b0);
    spiByte(op, rx);
    for (int k = 0; k < nAddr; k++) spiByte(a[23-8*k -: 8], rx);
    if (hasData) spiByte(d, rx);
    spiEnd();
  endtask

  task automatic testReset();
    chk("R13 wel", wel, 0);
    chk("R13 volSel", volSel, 0);
    chk("R13 sdoEn", sdoEn, 0);
    chk("R13 strobes", {statusWrStb, modifyStb}, 0);
  endtask

  task automatic testJedec(input bit m3);
    logic [7:0] rx;
    logic [7:0] exp [4];
    exp[0] = T_MFR; exp[1] = T_TYP; exp[2] = T_CAP; exp[3] = T_MFR;
    spiBegin(m3);
    enSeen = 1'b0;
    spiByte(8'h9F, rx);
    chk(m3 ? "R6 jedec opcode quiet m3" : "R6 jedec opcode quiet", enSeen, 0);
    for (int k = 0; k < 4; k++) begin
      enSeen = 1'b0;
      spiByte(8'h00, rx);
      chk(m3 ? "R1 R8 jedec byte mode3" : "R8 R12 jedec byte mode0", rx, exp[k]);
      chk("R8 jedec drive", enSeen, 1);
    end
    spiEnd();
    chk("R6 idle after jedec", sdoEn, 0);
  endtask

  task automatic testIdPair(input logic a0);
    logic [7:0] rx;
    logic [7:0] first, second;
    first  = a0 ? T_DEV : T_MFR;
    second = a0 ? T_MFR : T_DEV;
    spiBegin(1'b1);
    enSeen = 1'b0;
    spiByte(8'h90, rx);
    spiByte(8'h00, rx);
    spiByte(8'h00, rx);
    spiByte({7'h00, a0}, rx);
    chk("R6 id pair address quiet", enSeen, 0);
    for (int k = 0; k < 4; k++) begin
      spiByte(8'h00, rx);
      chk(a0 ? "R7 id pair swapped" : "R7 id pair", rx, (k % 2 == 0) ? first : second);
    end
    spiEnd();
  endtask

  task automatic testWake();
    logic [7:0] rx;
    spiBegin(1'b0);
    enSeen = 1'b0;
    spiByte(8'hAB, rx);
    for (int k = 0; k < 3; k++) spiByte(8'h00, rx);
    chk("R9 dummy quiet", enSeen, 0);
    for (int k = 0; k < 3; k++) begin
      spiByte(8'h00, rx);
      chk("R9 device repeat", rx, T_DEV);
    end
    spiEnd();
  endtask

  task automatic testLocked();
    int m0, s0;
    m0 = nMod; s0 = nStat;
    frame(8'hC7, 0, 24'h0, 1'b0, 8'h00);
    frame(8'h20, 3, 24'h001000, 1'b0, 8'h00);
    frame(8'h01, 0, 24'h0, 1'b1, 8'h77);
    chk("R3 no modify strobe", nMod - m0, 0);
    chk("R3 no status strobe", nStat - s0, 0);
    chk("R3 wel stays 0", wel, 0);
  endtask

  task automatic testWrenErase();
    int m0;
    m0 = nMod;
    enSeen = 1'b0;
    frame(8'h06, 0, 24'h0, 1'b0, 8'h00);
    chk("R2 wel set", wel, 1);
    chk("R6 wren quiet", enSeen, 0);
    frame(8'h20, 3, 24'h012345, 1'b0, 8'h00);
    chk("R4 one strobe", nMod - m0, 1);
    chk("R4 code", lastModCode, 8'h20);
    chk("R4 addr", lastModAddr, 24'h012345);
    chk("R4 wel cleared", wel, 0);
    frame(8'h06, 0, 24'h0, 1'b0, 8'h00);
    frame(8'h60, 0, 24'h0, 1'b0, 8'h00);
    chk("R4 chip erase strobe", nMod - m0, 2);
    chk("R4 chip erase addr", {lastModCode, lastModAddr}, {8'h60, 24'h0});
    chk("R4 wel cleared again", wel, 0);
  endtask

  task automatic testPartialAndSecurity();
    logic [7:0] rx;
    int m0;
    frame(8'h06, 0, 24'h0, 1'b0, 8'h00);
    m0 = nMod;
    spiBegin(1'b0);
    spiBits(8'hC7, 5, rx);
    spiEnd();
    chk("R11 wel kept", wel, 1);
    chk("R11 no strobe", nMod - m0, 0);
    frame(8'h44, 3, 24'h004007, 1'b0, 8'h00);
    chk("R10 bad window refused", nMod - m0, 0);
    chk("R10 wel kept", wel, 1);
    frame(8'h44, 3, 24'h012007, 1'b0, 8'h00);
    chk("R10 bad high byte refused", nMod - m0, 0);
    frame(8'h44, 3, 24'h002007, 1'b0, 8'h00);
    chk("R10 good window", nMod - m0, 1);
    chk("R10 addr", {lastModCode, lastModAddr}, {8'h44, 24'h002007});
    frame(8'h50, 0, 24'h0, 1'b0, 8'h00);
    spiBegin(1'b0);
    spiBits(8'h9F, 3, rx);
    spiEnd();
    chk("R11 volSel kept", volSel, 1);
    frame(8'h9F, 0, 24'h0, 1'b0, 8'h00);
    chk("R5 flag cleared", volSel, 0);
  endtask

  task automatic testStatus();
    int s0;
    s0 = nStat;
    frame(8'h50, 0, 24'h0, 1'b0, 8'h00);
    chk("R5 armed", volSel, 1);
    frame(8'h01, 0, 24'h0, 1'b1, 8'h3C);
    chk("R5 volatile strobe", nStat - s0, 1);
    chk("R5 volatile flag and data", {lastStatVol, lastStatData}, {1'b1, 8'h3C});
    chk("R5 disarmed", volSel, 0);
    frame(8'h06, 0, 24'h0, 1'b0, 8'h00);
    frame(8'h01, 0, 24'h0, 1'b1, 8'h5A);
    chk("R4 status strobe", nStat - s0, 2);
    chk("R4 non volatile data", {lastStatVol, lastStatData}, {1'b0, 8'h5A});
    chk("R4 wel cleared by status", wel, 0);
    frame(8'h50, 0, 24'h0, 1'b0, 8'h00);
    frame(8'h9F, 0, 24'h0, 1'b0, 8'h00);
    frame(8'h01, 0, 24'h0, 1'b1, 8'h11);
    chk("R5 intervening frame disarms", nStat - s0, 2);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testJedec(1'b0);
    testJedec(1'b1);
    testIdPair(1'b0);
    testIdPair(1'b1);
    testWake();
    testLocked();
    testWrenErase();
    testPartialAndSecurity();
    testStatus();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule